// File: doc/BRIEF.md
# Byte-Serial Market Feed Message Decoder

This block takes a binary market-data stream one byte per clock and cuts it into variable-length messages without ever holding the source back. Each message on the wire is a two-byte big-endian length followed by a body. The body starts with an ASCII type character. A small framing state machine reads the length and counts body bytes. A two-state parser looks at the type byte and decides, in the same cycle, which of eight per-type field decoders the rest of the body belongs to. It then broadcasts every body byte, with its index, on one shared bus.

Only the selected decoder captures bytes. When the last body byte arrives, that decoder publishes its fields and raises its own valid bit for a single cycle. Each decoder extracts a 64-bit key from body bytes 1 to 8 and a 32-bit value from the last four body bytes. A body whose type is unknown, or whose framed length does not match its type, is read through and thrown away. A sticky error flag records the event.

Top module: `mfd_decoder`

## Requirements
- R1: `in_ready` is high whenever reset is low, and a byte is taken on every clock edge where `in_valid` is high. Back-to-back messages need no idle cycle between them.
- R2: A frame is a two-byte big-endian body length, high byte first, followed by exactly that many body bytes. The next frame's length follows at once.
- R3: Supported body types and their lengths (the type byte is included in the length) are: 'S'=12, 'A'=36, 'F'=40, 'E'=31, 'C'=36, 'X'=23, 'D'=19, 'U'=35. These map to valid bit and record index 0 to 7 in that order.
- R4: `out_key[i]` is body bytes 1 to 8 of the last completed type-i message, concatenated big-endian (byte 1 is the most significant).
- R5: `out_val[i]` is the final four body bytes of that message, concatenated big-endian.
- R6: `out_valid[i]` is high for exactly one cycle per good message. It is registered by the second clock edge after the edge that accepted the last body byte.
- R7: At most one bit of `out_valid` is high in any cycle.
- R8: A record's key and value hold their values until the next good message of the same type completes, including while other types complete.
- R9: A body with an unsupported type byte is consumed without raising any valid bit, and `err` is set and stays set.
- R10: A supported type whose framed length differs from its R3 length is consumed without raising any valid bit, and `err` is set.
- R11: After a discarded body, the next frame is decoded normally.
- R12: A synchronous reset clears `out_valid`, `out_key`, `out_val` and `err`, and returns framing to expect a length high byte.
- R13: Cycles with `in_valid` low pause the stream and cause no byte loss or duplication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte qualifier |
| in_data | input | 8 | Input stream byte |
| in_ready | output | 1 | Stream acceptance, high outside reset |
| out_valid | output | 8 | One-cycle completion pulse per type |
| out_key | output | 8x64 | Per-type key field, body bytes 1 to 8 |
| out_val | output | 8x32 | Per-type value field, last four body bytes |
| err | output | 1 | Sticky discarded-body flag |

## Verification
The decoder is driven with a single message, a run of all eight types back to back with no idle cycles, and a message split by idle gaps. Together these separate correct byte counting from errors that only show up at frame boundaries or when the stream is paused. Body bytes come from a seeded pattern, so a shifted or swapped field gives a wrong key or value rather than a coincidental match. An unknown type and a wrong length are each followed by a good frame, which shows that the discard path keeps framing aligned. A second message of one type checks that records update only on their own type.

// File: rtl/mfd_pkg.sv
package mfd_pkg;

    localparam int NTYPES = 8;
    localparam int LW     = 16;
    localparam int KEYW   = 64;
    localparam int VALW   = 32;
    localparam int KEY_FIRST = 1;
    localparam int KEY_LAST  = KEY_FIRST + KEYW / 8 - 1;

    typedef struct packed {
        logic          vld;
        logic [7:0]    data;
        logic [LW-1:0] idx;
        logic          last;
    } bcast_t;

    function automatic logic [7:0] type_code(input int i);
        case (i)
            0: return 8'h53;
            1: return 8'h41;
            2: return 8'h46;
            3: return 8'h45;
            4: return 8'h43;
            5: return 8'h58;
            6: return 8'h44;
            default: return 8'h55;
        endcase
    endfunction

    function automatic logic [LW-1:0] type_len(input int i);
        case (i)
            0: return 16'd12;
            1: return 16'd36;
            2: return 16'd40;
            3: return 16'd31;
            4: return 16'd36;
            5: return 16'd23;
            6: return 16'd19;
            default: return 16'd35;
        endcase
    endfunction

endpackage

// File: rtl/mfd_frame_fsm.sv
module mfd_frame_fsm
    import mfd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          vld,
    input  logic [7:0]    data,
    output logic          body_vld,
    output logic [LW-1:0] body_idx,
    output logic          body_last,
    output logic [LW-1:0] body_len,
    output logic          zero_err
);
    typedef enum logic [1:0] {F_LEN_HI, F_LEN_LO, F_BODY} fstate_t;

    fstate_t       st;
    logic [7:0]    len_hi;
    logic [LW-1:0] len_q;
    logic [LW-1:0] idx_q;

    assign body_vld  = vld && (st == F_BODY);
    assign body_idx  = idx_q;
    assign body_len  = len_q;
    assign body_last = (idx_q == len_q - 16'd1);
    assign zero_err  = vld && (st == F_LEN_LO) && ({len_hi, data} == 16'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= F_LEN_HI;
            len_hi <= '0;
            len_q  <= '0;
            idx_q  <= '0;
        end else if (vld) begin
            case (st)
                F_LEN_HI: begin
                    len_hi <= data;
                    st     <= F_LEN_LO;
                end
                F_LEN_LO: begin
                    len_q <= {len_hi, data};
                    idx_q <= '0;
                    st    <= ({len_hi, data} == 16'd0) ? F_LEN_HI : F_BODY;
                end
                default: begin
                    if (body_last) st <= F_LEN_HI;
                    else           idx_q <= idx_q + 16'd1;
                end
            endcase
        end
    end

    // R2: a length high byte is always followed by the length low byte
    p_hi_then_lo_r2: assert property (@(posedge clk) disable iff (rst)
        (st == F_LEN_HI && vld) |=> (st == F_LEN_LO));

    // R2: the final body byte hands framing back to the length field
    p_body_end_r2: assert property (@(posedge clk) disable iff (rst)
        (body_vld && body_last) |=> (st == F_LEN_HI));

endmodule

// File: rtl/mfd_parser.sv
module mfd_parser
    import mfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              body_vld,
    input  logic [7:0]        body_data,
    input  logic [LW-1:0]     body_idx,
    input  logic              body_last,
    input  logic [LW-1:0]     body_len,
    output bcast_t            bus,
    output logic [NTYPES-1:0] bus_sel,
    output logic              bad_type
);
    typedef enum logic {P_TYPE, P_FWD} pstate_t;

    pstate_t           st;
    logic [NTYPES-1:0] sel_keep;
    logic [NTYPES-1:0] hit;
    logic [NTYPES-1:0] route;

    always_comb begin
        for (int i = 0; i < NTYPES; i++)
            hit[i] = (body_data == type_code(i)) && (body_len == type_len(i));
        route    = (st == P_TYPE) ? hit : sel_keep;
        bad_type = body_vld && (st == P_TYPE) && (hit == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= P_TYPE;
            sel_keep <= '0;
            bus      <= '0;
            bus_sel  <= '0;
        end else begin
            bus.vld  <= body_vld;
            bus.data <= body_data;
            bus.idx  <= body_idx;
            bus.last <= body_last;
            bus_sel  <= body_vld ? route : '0;
            if (body_vld) begin
                if (st == P_TYPE) sel_keep <= hit;
                if (body_last)    st <= P_TYPE;
                else              st <= P_FWD;
            end
        end
    end

    // R9 R10: a rejected type byte routes to no decoder
    p_drop_r9: assert property (@(posedge clk) disable iff (rst)
        bad_type |=> (bus_sel == '0));

    // R7: the broadcast selection never names two decoders
    p_sel_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bus_sel));

endmodule

// File: rtl/mfd_type_dec.sv
module mfd_type_dec
    import mfd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  bcast_t          bus,
    input  logic            sel,
    output logic            valid,
    output logic [KEYW-1:0] key,
    output logic [VALW-1:0] val
);
    logic [KEYW-1:0] key_w;
    logic [VALW-1:0] val_w;
    logic            take;

    assign take = sel && bus.vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            key_w <= '0;
            val_w <= '0;
            key   <= '0;
            val   <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (take) begin
                if (bus.idx >= LW'(KEY_FIRST) && bus.idx <= LW'(KEY_LAST))
                    key_w <= {key_w[KEYW-9:0], bus.data};
                val_w <= {val_w[VALW-9:0], bus.data};
                if (bus.last) begin
                    key   <= key_w;
                    val   <= {val_w[VALW-9:0], bus.data};
                    valid <= 1'b1;
                end
            end
        end
    end

    // R6: completion is a single-cycle pulse
    p_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    // R8: published fields change only alongside a completion
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !valid |-> ($stable(key) && $stable(val)));

endmodule

// File: rtl/mfd_decoder.sv
module mfd_decoder
    import mfd_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [7:0]                 in_data,
    output logic                       in_ready,
    output logic [NTYPES-1:0]          out_valid,
    output logic [NTYPES-1:0][KEYW-1:0] out_key,
    output logic [NTYPES-1:0][VALW-1:0] out_val,
    output logic                       err
);
    logic              s1_vld;
    logic [7:0]        s1_data;
    logic              body_vld, body_last, zero_err, bad_type;
    logic [LW-1:0]     body_idx, body_len;
    bcast_t            bus;
    logic [NTYPES-1:0] bus_sel;

    assign in_ready = !rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld  <= 1'b0;
            s1_data <= '0;
            err     <= 1'b0;
        end else begin
            s1_vld  <= in_valid;
            s1_data <= in_data;
            if (bad_type || zero_err) err <= 1'b1;
        end
    end

    mfd_frame_fsm u_frame (
        .clk(clk), .rst(rst), .vld(s1_vld), .data(s1_data),
        .body_vld(body_vld), .body_idx(body_idx), .body_last(body_last),
        .body_len(body_len), .zero_err(zero_err)
    );

    mfd_parser u_parse (
        .clk(clk), .rst(rst), .body_vld(body_vld), .body_data(s1_data),
        .body_idx(body_idx), .body_last(body_last), .body_len(body_len),
        .bus(bus), .bus_sel(bus_sel), .bad_type(bad_type)
    );

    for (genvar g = 0; g < NTYPES; g++) begin : g_dec
        mfd_type_dec u_dec (
            .clk(clk), .rst(rst), .bus(bus), .sel(bus_sel[g]),
            .valid(out_valid[g]), .key(out_key[g]), .val(out_val[g])
        );
    end

    // R7: completions are one-hot across all records
    p_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_valid));

    // R9: the error flag is sticky until reset
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R1: the block accepts input whenever it is out of reset
    p_ready_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> in_ready);

endmodule

// File: tb/mfd_decoder_bench.sv
`timescale 1ns/1ps
module mfd_decoder_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_ready, err;
    logic [7:0] out_valid;
    logic [7:0][63:0] out_key;
    logic [7:0][31:0] out_val;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int multi = 0;
    int vcnt[8];
    int vcyc[8];
    int acc[8];

    localparam string CODES = "SAFECXDU";
    int lens[8] = '{12, 36, 40, 31, 36, 23, 19, 35};

    mfd_decoder u_mfd_decoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_key(out_key),
        .out_val(out_val), .err(err)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < 8; i++)
                if (out_valid[i]) begin vcnt[i]++; vcyc[i] = cyc; end
            if ($countones(out_valid) > 1) multi++;
        end
    end

    function automatic logic [7:0] pat(int seed, int k);
        return 8'((seed * 13 + k * 29 + 5) & 255);
    endfunction

    function automatic logic [63:0] exp_key(int seed);
        logic [63:0] r = '0;
        for (int k = 1; k <= 8; k++) r = {r[55:0], pat(seed, k)};
        return r;
    endfunction

    function automatic logic [31:0] exp_val(int seed, int len);
        logic [31:0] r = '0;
        for (int k = len - 4; k < len; k++) r = {r[23:0], pat(seed, k)};
        return r;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic put(logic [7:0] b, int gap);
        if (gap > 0) begin
            in_valid = 1'b0;
            repeat (gap) @(negedge clk);
        end
        in_valid = 1'b1;
        in_data  = b;
        @(negedge clk);
    endtask

    task automatic send(logic [7:0] t, int flen, int seed, int gap, output int last_acc);
        put(8'(flen >> 8), 0);
        put(8'(flen), gap);
        for (int k = 0; k < flen; k++)
            put(k == 0 ? t : pat(seed, k), gap);
        last_acc = cyc;
        in_valid = 1'b0;
    endtask

    task automatic idle(int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_rec(int i, int seed, int cnt0, string req);
        chk(vcnt[i] == cnt0 + 1, req, "pulse count", vcnt[i], cnt0 + 1);
        chk(vcyc[i] == acc[i] + 2, "R6", "completion cycle", vcyc[i], acc[i] + 2);
        chk(out_key[i] == exp_key(seed), "R4", "key", out_key[i], exp_key(seed));
        chk(out_val[i] == exp_val(seed, lens[i]), "R5", "value", out_val[i], exp_val(seed, lens[i]));
    endtask

    task automatic t_reset();
        do_reset();
        chk(out_valid == 8'h00, "R12", "valid after reset", out_valid, 0);
        chk(err == 1'b0, "R12", "err after reset", err, 0);
        chk(in_ready == 1'b1, "R1", "ready", in_ready, 1);
        chk(out_key[3] == 64'd0, "R12", "key after reset", out_key[3], 0);
    endtask

    task automatic t_single();
        int c0 = vcnt[0];
        send(CODES[0], lens[0], 3, 0, acc[0]);
        idle(4);
        check_rec(0, 3, c0, "R3");
        chk(err == 1'b0, "R2", "no error on good frame", err, 0);
    endtask

    task automatic t_all_types();
        int c0[8];
        for (int i = 0; i < 8; i++) c0[i] = vcnt[i];
        for (int i = 0; i < 8; i++) send(CODES[i], lens[i], 40 + i, 0, acc[i]);
        idle(4);
        for (int i = 0; i < 8; i++) check_rec(i, 40 + i, c0[i], "R1");
        chk(multi == 0, "R7", "overlapping valids", multi, 0);
    endtask

    task automatic t_gaps();
        int c0 = vcnt[1];
        send(CODES[1], lens[1], 77, 2, acc[1]);
        idle(4);
        check_rec(1, 77, c0, "R13");
    endtask

    task automatic t_hold();
        int c0 = vcnt[0];
        chk(out_key[0] == exp_key(40), "R8", "S key kept", out_key[0], exp_key(40));
        send(CODES[0], lens[0], 91, 0, acc[0]);
        idle(4);
        check_rec(0, 91, c0, "R8");
        chk(out_key[1] == exp_key(77), "R8", "A key kept", out_key[1], exp_key(77));
    endtask

    task automatic t_unknown();
        int sum0 = 0;
        int sum1 = 0;
        int c0;
        int dummy;
        for (int i = 0; i < 8; i++) sum0 += vcnt[i];
        send(8'h5A, 10, 5, 0, dummy);
        idle(4);
        for (int i = 0; i < 8; i++) sum1 += vcnt[i];
        chk(sum1 == sum0, "R9", "valids on unknown type", sum1, sum0);
        chk(err == 1'b1, "R9", "err set", err, 1);
        c0 = vcnt[6];
        send(CODES[6], lens[6], 12, 0, acc[6]);
        idle(4);
        check_rec(6, 12, c0, "R11");
        chk(err == 1'b1, "R9", "err sticky", err, 1);
    endtask

    task automatic t_badlen();
        int sum0 = 0;
        int sum1 = 0;
        int c0;
        int dummy;
        do_reset();
        chk(err == 1'b0, "R12", "err cleared", err, 0);
        for (int i = 0; i < 8; i++) sum0 += vcnt[i];
        send(CODES[5], lens[5] + 1, 8, 0, dummy);
        c0 = vcnt[3];
        send(CODES[3], lens[3], 19, 0, acc[3]);
        idle(4);
        for (int i = 0; i < 8; i++) sum1 += vcnt[i];
        chk(sum1 == sum0 + 1, "R10", "only the good frame completes", sum1, sum0 + 1);
        chk(err == 1'b1, "R10", "err set", err, 1);
        check_rec(3, 19, c0, "R11");
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin vcnt[i] = 0; vcyc[i] = 0; acc[i] = 0; end
        @(negedge clk);
        t_reset();
        t_single();
        t_all_types();
        t_gaps();
        t_hold();
        t_unknown();
        t_badlen();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule